// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped front end for a fuse array of 32-bit words. Software steers the array one register at a time. It writes a word address, a bit index, a data bit and several enable, clock and test controls. Two registers then act on the array. A read of the data-out register returns the addressed word, but only when the three enables that gate it are all set. A write of 1 to the write-enable register burns a single bit.

A record is kept for each bit that has been burned. A second attempt to burn the same bit is refused, and a sticky error flag records it. On reset every word reads as all ones, except a pair of words that carries a serial number and its bitwise complement. The per-bit record is cleared at the same time.

The bus takes only whole 32-bit words. The byte offsets of the registers are fixed: ADDR 0x00, BITSEL 0x04, REDUN 0x08, CHIPEN 0x0C, FCLK 0x10, DIN 0x14, DOUT 0x18, STROBE 0x1C, PROG 0x20, TCTL 0x24, TMODE 0x28, TREP 0x2C, TREAD 0x30, TRIM 0x34, WREN 0x38 and ERR 0x3C.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads 0, including ERR.
- R2: A DOUT read returns the fuse word at ADDR only when bit 0 is set in each of CHIPEN, STROBE and TRIM. Otherwise the read returns 32'h000000FF.
- R3: Each control register reads back the last full 32-bit value written to it, with two exceptions. ADDR keeps only the low log2(WORDS) bits of the value written. WREN keeps only bit 0.
- R4: DOUT is read-only, and a write to it changes neither the array nor any register.
- R5: A write to WREN with bit 0 = 1, while REDUN reads 0, programs one bit of the word at ADDR. The bit programmed is bit BITSEL[4:0], and it takes the value of DIN bit 0. The new value is visible from the following cycle.
- R6: While REDUN is nonzero, a write to WREN programs nothing and leaves the written map unchanged.
- R7: An attempt to program a bit that was already programmed since reset leaves the word unchanged and sets ERR bit 0. Bits that have not been programmed in the same word can still be programmed.
- R8: An access at an offset that is not a register returns 0 and sets ERR bit 1. This covers a misaligned offset and any offset at or above 0x40. A write to such an offset changes nothing else.
- R9: Writing 1 to an ERR bit clears that bit. Writing 0 to it leaves it unchanged.
- R10: After reset, word SER_ADDR holds SERIAL and word SER_ADDR+1 holds ~SERIAL. Every other word holds all ones. The written map is clear, so any bit can be programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_AW | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as the read |

## Verification
Suppose the record of written bits is wrong. A bit that was already burned would then be burned a second time, and the following DOUT read would show the changed word. The error flag would also stay clear. Both effects can be seen one cycle after the WREN write.

A wrong enable gate or a wrong address mask shows on the very next DOUT read as the wrong word or a wrongly blocked value. A reset that does not restore the array shows on the first sweep of reads after reset. That sweep shows a missing serial pair, or a bit that is still burned.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_CNT = 16;

  typedef enum logic [3:0] {
    RG_ADDR   = 4'd0,
    RG_BITSEL = 4'd1,
    RG_REDUN  = 4'd2,
    RG_CHIPEN = 4'd3,
    RG_FCLK   = 4'd4,
    RG_DIN    = 4'd5,
    RG_DOUT   = 4'd6,
    RG_STROBE = 4'd7,
    RG_PROG   = 4'd8,
    RG_TCTL   = 4'd9,
    RG_TMODE  = 4'd10,
    RG_TREP   = 4'd11,
    RG_TREAD  = 4'd12,
    RG_TRIM   = 4'd13,
    RG_WREN   = 4'd14,
    RG_ERR    = 4'd15
  } reg_sel_e;

  localparam int ERR_ONCE = 0;
  localparam int ERR_MAP  = 1;
  localparam logic [DATA_W-1:0] DOUT_BLOCKED = 32'h0000_00FF;
endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_fuse_pkg::*;
#(
  parameter int AW    = 12,
  parameter int BIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              mapped,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              once_err,
  output logic [DATA_W-1:0] rdata,
  output logic [AW-1:0]     word_addr,
  output logic [BIT_W-1:0]  bit_sel,
  output logic              din_bit,
  output logic              redun_nz,
  output logic              dout_en,
  output logic              prog_req,
  output logic [1:0]        err_flags
);
  logic [DATA_W-1:0] plain_q [REG_CNT];
  logic [AW-1:0]     addr_q;
  logic              wren_q;
  logic [1:0]        err_q;
  logic              hit;

  assign hit = wr_stb && mapped;

  genvar g;
  generate
    for (g = 0; g < REG_CNT; g++) begin : g_reg
      if (g == int'(RG_ADDR) || g == int'(RG_DOUT) ||
          g == int'(RG_WREN) || g == int'(RG_ERR)) begin : g_special
        assign plain_q[g] = '0;
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst) plain_q[g] <= '0;
          else if (hit && sel == reg_sel_e'(g)) plain_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wren_q <= 1'b0;
    end else if (hit) begin
      if (sel == RG_ADDR) addr_q <= wdata[AW-1:0];
      if (sel == RG_WREN) wren_q <= wdata[0];
    end
  end

  logic [1:0] err_clr, err_set;
  assign err_clr = (hit && sel == RG_ERR) ? wdata[1:0] : 2'b00;
  assign err_set = {(wr_stb || rd_stb) && !mapped, once_err};

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (err_q & ~err_clr) | err_set;
  end

  always_comb begin
    rdata = '0;
    case (sel)
      RG_ADDR: rdata[AW-1:0] = addr_q;
      RG_WREN: rdata[0]      = wren_q;
      RG_ERR:  rdata[1:0]    = err_q;
      default: rdata         = plain_q[sel];
    endcase
  end

  assign word_addr = addr_q;
  assign bit_sel   = plain_q[RG_BITSEL][BIT_W-1:0];
  assign din_bit   = plain_q[RG_DIN][0];
  assign redun_nz  = |plain_q[RG_REDUN];
  assign dout_en   = plain_q[RG_CHIPEN][0] && plain_q[RG_STROBE][0] &&
                     plain_q[RG_TRIM][0];
  assign prog_req  = hit && sel == RG_WREN && wdata[0] && !redun_nz;
  assign err_flags = err_q;
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_fuse_pkg::*;
#(
  parameter int                WORDS    = 4096,
  parameter int                AW       = 12,
  parameter int                BIT_W    = 5,
  parameter int                SER_ADDR = 252,
  parameter logic [DATA_W-1:0] SERIAL   = 32'hA5C3_0017
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic              din_bit,
  input  logic              prog_req,
  output logic [DATA_W-1:0] word,
  output logic              once_err
);
  localparam logic [AW-1:0] SER_A = AW'(SER_ADDR);
  localparam logic [AW-1:0] SER_B = AW'(SER_ADDR + 1);

  logic [DATA_W-1:0] fuse_mem [WORDS];
  logic [DATA_W-1:0] wmap_mem [WORDS];
  logic [WORDS-1:0]  touched_q;

  function automatic logic [DATA_W-1:0] init_word(input logic [AW-1:0] a);
    if (a == SER_A)      return SERIAL;
    else if (a == SER_B) return ~SERIAL;
    else                 return '1;
  endfunction

  logic [DATA_W-1:0] cur_fuse, cur_wmap, next_fuse, next_wmap;
  logic              already, do_prog;

  always_comb begin
    cur_fuse  = touched_q[addr] ? fuse_mem[addr] : init_word(addr);
    cur_wmap  = touched_q[addr] ? wmap_mem[addr] : '0;
    already   = cur_wmap[bit_sel];
    next_fuse = cur_fuse;
    next_fuse[bit_sel] = din_bit;
    next_wmap = cur_wmap;
    next_wmap[bit_sel] = 1'b1;
  end

  assign do_prog  = prog_req && !already && !rst;
  assign once_err = prog_req && already && !rst;
  assign word     = cur_fuse;

  always_ff @(posedge clk) begin
    if (do_prog) begin
      fuse_mem[addr] <= next_fuse;
      wmap_mem[addr] <= next_wmap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          touched_q <= '0;
    else if (do_prog) touched_q[addr] <= 1'b1;
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int                WORDS    = 4096,
  parameter int                BUS_AW   = 12,
  parameter int                SER_ADDR = 252,
  parameter logic [DATA_W-1:0] SERIAL   = 32'hA5C3_0017
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data
);
  localparam int AW    = $clog2(WORDS);
  localparam int BIT_W = $clog2(DATA_W);

  logic              mapped;
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_rdata, fuse_word;
  logic [AW-1:0]     word_addr;
  logic [BIT_W-1:0]  bit_sel;
  logic              din_bit, redun_nz, dout_en, prog_req, once_err;
  logic [1:0]        err_flags;

  assign mapped = (req_addr[1:0] == 2'b00) && ((req_addr >> 6) == '0);
  assign sel    = reg_sel_e'(req_addr[5:2]);

  otp_ctrl_regs #(.AW(AW), .BIT_W(BIT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (req_valid && req_write),
    .rd_stb    (req_valid && !req_write),
    .mapped    (mapped),
    .sel       (sel),
    .wdata     (req_wdata),
    .once_err  (once_err),
    .rdata     (ctrl_rdata),
    .word_addr (word_addr),
    .bit_sel   (bit_sel),
    .din_bit   (din_bit),
    .redun_nz  (redun_nz),
    .dout_en   (dout_en),
    .prog_req  (prog_req),
    .err_flags (err_flags)
  );

  otp_fuse_store #(
    .WORDS(WORDS), .AW(AW), .BIT_W(BIT_W),
    .SER_ADDR(SER_ADDR), .SERIAL(SERIAL)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .addr     (word_addr),
    .bit_sel  (bit_sel),
    .din_bit  (din_bit),
    .prog_req (prog_req),
    .word     (fuse_word),
    .once_err (once_err)
  );

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_write && mapped) begin
      if (sel == RG_DOUT) rd_data = dout_en ? fuse_word : DOUT_BLOCKED;
      else                rd_data = ctrl_rdata;
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int BUS_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [BUS_AW-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rd_data,
  input logic [1:0]        err_flags,
  input logic [31:0]       fuse_word,
  input logic              once_err,
  input logic              dout_en,
  input logic              redun_nz
);
  logic unmapped, is_dout, is_wren, is_err;
  assign unmapped = (req_addr[1:0] != 2'b00) || ((req_addr >> 6) != '0);
  assign is_dout  = req_addr == BUS_AW'(8'h18);
  assign is_wren  = req_addr == BUS_AW'(8'h38);
  assign is_err   = req_addr == BUS_AW'(8'h3C);

  assert_dout_blocked_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && is_dout && !dout_en) |-> rd_data == 32'h0000_00FF);

  assert_dout_ro_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && is_dout) |=> $stable(fuse_word));

  assert_redun_block_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && is_wren && redun_nz) |=> $stable(fuse_word));

  assert_once_keep_R7: assert property (@(posedge clk) disable iff (rst)
    once_err |=> $stable(fuse_word));

  assert_once_flag_R7: assert property (@(posedge clk) disable iff (rst)
    once_err |=> err_flags[0]);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && unmapped) |-> rd_data == 32'h0);

  assert_unmapped_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && unmapped) |=> err_flags[1]);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && is_err && req_wdata[0]) |=> !err_flags[0]);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_data   (rd_data),
  .err_flags (err_flags),
  .fuse_word (fuse_word),
  .once_err  (once_err),
  .dout_en   (dout_en),
  .redun_nz  (redun_nz)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;
  localparam int          WORDS  = 64;
  localparam int          SER    = 10;
  localparam logic [31:0] SERIAL = 32'h5A5A_1234;

  localparam logic [11:0] O_ADDR = 12'h00, O_BITSEL = 12'h04, O_REDUN = 12'h08,
                          O_CHIPEN = 12'h0C, O_DIN = 12'h14, O_DOUT = 12'h18,
                          O_STROBE = 12'h1C, O_TRIM = 12'h34, O_WREN = 12'h38,
                          O_ERR = 12'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mdl [WORDS];

  otp_fuse_ctrl #(.WORDS(WORDS), .BUS_AW(12), .SER_ADDR(SER), .SERIAL(SERIAL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #2; d = rd_data;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic model_init();
    for (int i = 0; i < WORDS; i++) mdl[i] = 32'hFFFF_FFFF;
    mdl[SER]     = SERIAL;
    mdl[SER + 1] = ~SERIAL;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    model_init();
  endtask

  task automatic enables_on();
    wr(O_CHIPEN, 32'h1); wr(O_STROBE, 32'h1); wr(O_TRIM, 32'h1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d, e;
    #1;
    do_reset();

    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i++) begin
      if (i == 6) continue;
      rd(12'(i * 4), d);
      chk($sformatf("R1 reg@%0h after reset", i * 4), d, 32'h0);
    end

    // R2: all eight enable combinations on word 0 (all ones when open)
    for (int c = 0; c < 8; c++) begin
      wr(O_CHIPEN, {31'b0, c[0]}); wr(O_STROBE, {31'b0, c[1]}); wr(O_TRIM, {31'b0, c[2]});
      rd(O_DOUT, d);
      chk($sformatf("R2 enables=%0d", c), d, (c == 7) ? 32'hFFFF_FFFF : 32'h0000_00FF);
    end

    // R10: full sweep of reset contents
    for (int w = 0; w < WORDS; w++) begin
      wr(O_ADDR, 32'(w));
      rd(O_DOUT, d);
      chk($sformatf("R10 word %0d", w), d, mdl[w]);
    end

    // R3: plain registers hold whole words
    for (int i = 1; i < 14; i++) begin
      if (i == 6) continue;
      e = 32'hA000_0F00 ^ (32'(i) * 32'h0101_0101);
      wr(12'(i * 4), e);
      rd(12'(i * 4), d);
      chk($sformatf("R3 readback @%0h", i * 4), d, e);
    end
    enables_on();
    wr(O_ADDR, 32'hFFFF_FFFF);
    rd(O_ADDR, d);
    chk("R3 ADDR masked", d, 32'(WORDS - 1));

    // R6: WREN with REDUN nonzero, also R3 WREN keeps bit 0
    wr(O_REDUN, 32'h4); wr(O_BITSEL, 32'd7); wr(O_DIN, 32'h0);
    wr(O_WREN, 32'hFFFF_FFFF);
    rd(O_WREN, d);
    chk("R3 WREN keeps bit0", d, 32'h1);
    rd(O_DOUT, d);
    chk("R6 no program with REDUN set", d, mdl[WORDS - 1]);
    wr(O_WREN, 32'hFFFF_FFFE);
    rd(O_WREN, d);
    chk("R3 WREN bit0 clear", d, 32'h0);
    wr(O_REDUN, 32'h0);
    wr(O_WREN, 32'h1);
    mdl[WORDS - 1][7] = 1'b0;
    rd(O_DOUT, d);
    chk("R6 map untouched, R5 program after REDUN cleared", d, mdl[WORDS - 1]);
    rd(O_ERR, d);
    chk("R6 no once error", d, 32'h0);

    // R5: program every bit of word 3
    wr(O_ADDR, 32'd3);
    for (int b = 0; b < 32; b++) begin
      logic v;
      v = b[0] ^ b[2];
      wr(O_BITSEL, 32'(b)); wr(O_DIN, {31'b0, v}); wr(O_WREN, 32'h1);
      mdl[3][b] = v;
      rd(O_DOUT, d);
      chk($sformatf("R5 word3 bit %0d", b), d, mdl[3]);
    end
    rd(O_ERR, d);
    chk("R5 no error during sweep", d, 32'h0);

    // R4: write to DOUT ignored
    wr(O_DOUT, 32'h1234_5678);
    rd(O_DOUT, d);
    chk("R4 DOUT write ignored", d, mdl[3]);

    // R7: reprogram bit 0 with opposite value
    wr(O_BITSEL, 32'd0); wr(O_DIN, {31'b0, ~mdl[3][0]}); wr(O_WREN, 32'h1);
    rd(O_DOUT, d);
    chk("R7 word unchanged", d, mdl[3]);
    rd(O_ERR, d);
    chk("R7 once flag", d, 32'h1);

    // R9: write-one-to-clear
    wr(O_ERR, 32'h2);
    rd(O_ERR, d);
    chk("R9 zero leaves bit", d, 32'h1);
    wr(O_ERR, 32'h1);
    rd(O_ERR, d);
    chk("R9 one clears bit", d, 32'h0);

    // R8: unmapped reads and writes
    rd(12'h040, d); chk("R8 read 0x40", d, 32'h0);
    rd(12'h015, d); chk("R8 misaligned read", d, 32'h0);
    rd(12'h800, d); chk("R8 read 0x800", d, 32'h0);
    rd(O_ERR, d);   chk("R8 map flag", d, 32'h2);
    wr(O_ERR, 32'h3);
    wr(12'h016, 32'hDEAD_BEEF);
    wr(12'h044, 32'hDEAD_BEEF);
    rd(O_DIN, d);   chk("R8 DIN untouched", d, {31'b0, ~mdl[3][0]});
    rd(O_DOUT, d);  chk("R8 array untouched", d, mdl[3]);
    rd(O_ERR, d);   chk("R8 write flag", d, 32'h2);

    // R10: reset restores contents and clears written map
    do_reset();
    rd(O_ERR, d); chk("R1 ERR after second reset", d, 32'h0);
    enables_on();
    wr(O_ADDR, 32'd3);
    rd(O_DOUT, d); chk("R10 word3 restored", d, 32'hFFFF_FFFF);
    wr(O_ADDR, 32'(SER));
    rd(O_DOUT, d); chk("R10 serial", d, SERIAL);
    wr(O_ADDR, 32'(SER + 1));
    rd(O_DOUT, d); chk("R10 serial complement", d, ~SERIAL);
    wr(O_ADDR, 32'd3); wr(O_BITSEL, 32'd0); wr(O_DIN, 32'h0); wr(O_WREN, 32'h1);
    rd(O_DOUT, d); chk("R10 bit programmable again", d, 32'hFFFF_FFFE);
    rd(O_ERR, d);  chk("R10 no once error", d, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule